// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the host's transmit-data input and the control line of a single-wire bus driver. It passes a low transmit level through as a dominant command while the transceiver is in its communicating mode, and it watches how long the transmit line has been held low without a break. If the low time runs past a programmable limit, the guard concludes that the host or its wiring is stuck. It then forces the driver recessive, so that one faulty node cannot block the whole bus.

Once tripped, the guard gives the driver back only after the transmit line has been continuously high for a qualifying time. A brief high pulse therefore cannot re-arm it. Time is measured in ticks of an external timebase strobe, so the limits scale with the tick rate. The raw transmit level is always mirrored to the mode controller, even while the guard is tripped. That controller can then still see a held-low line and take the low-power sleep path when the enable is dropped.

Top module: `txd_dom_guard`

## Requirements
- R1: `drv_dom` is 1 only when `norm_en` is 1, `txd_sync` is 0 and the guard is not tripped; a high `txd_sync` gives `drv_dom` = 0 in the same cycle.
- R2: While `norm_en` is 1 and `txd_sync` is 0, a low-time counter advances on each `tick`. After TMO_TICKS+1 ticks, `drv_dom` drops to 0 in the cycle after the clock edge that counts the last tick, and `tmo_flag` rises one clock later.
- R3: Any clock edge that samples `txd_sync` = 1 clears the low-time counter, so a single high cycle between two low runs of TMO_TICKS ticks each prevents a trip.
- R4: The low-time counter saturates instead of wrapping; a line held low far beyond the limit keeps `drv_dom` at 0 and `tmo_flag` at 1.
- R5: A tripped guard releases only after `txd_sync` has stayed 1 for REL_TICKS+1 ticks; `tmo_flag` clears one clock after the qualifying tick. Any low sample restarts the qualification, and the guard stays tripped.
- R6: `txd_level` always equals `txd_sync`, including while tripped.
- R7: With `norm_en` = 0, `drv_dom` is 0. One clock with `norm_en` = 0 clears both the low-time counter and the tripped state.
- R8: After reset, `tmo_flag` is 0 and the low-time count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle timebase strobe that sets the counting granularity |
| norm_en | input | 1 | High while the transceiver is in its communicating mode |
| txd_sync | input | 1 | Synchronised transmit data; 0 requests dominant |
| drv_dom | output | 1 | Driver command; 1 drives the bus dominant |
| tmo_flag | output | 1 | 1 while the guard is tripped |
| txd_level | output | 1 | Raw transmit level reported to the mode controller |

## Verification
The bench builds the guard with TMO_TICKS = 20 and REL_TICKS = 3 and drives `tick` itself, one strobe per task step. With these values, the exact trip tick, the saturation region, the release qualification and its restart can all be reached in a few hundred cycles. The defaults stand for millisecond-scale limits that would otherwise need tens of thousands of ticks. The small values also put the tick just before the limit and the tick just past it next to each other, so both sides of every boundary are sampled.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic {
        G_ARMED   = 1'b0,
        G_TRIPPED = 1'b1
    } guard_st_e;

    typedef struct packed {
        logic trip_hit;
        logic rel_hit;
    } guard_evt_t;

    function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
        return (cur >= lim) ? lim : cur + 1;
    endfunction

endpackage

// File: rtl/txg_tick_ctr.sv
module txg_tick_ctr #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic full
);
    import txg_pkg::*;

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= CW'(sat_inc(32'(cnt), LIMIT));
        end
    end

    assign full = (cnt == LIM_V);

    // R4: the count never passes its saturation value
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM_V);

    // R3: a clear empties the counter by the next edge
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

endmodule

// File: rtl/txg_guard_fsm.sv
module txg_guard_fsm (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 norm_en,
    input  txg_pkg::guard_evt_t  evt,
    output txg_pkg::guard_st_e   st
);
    import txg_pkg::*;

    guard_st_e st_nx;

    always_comb begin
        st_nx = st;
        if (!norm_en) begin
            st_nx = G_ARMED;
        end else begin
            unique case (st)
                G_ARMED:   if (evt.trip_hit) st_nx = G_TRIPPED;
                G_TRIPPED: if (evt.rel_hit)  st_nx = G_ARMED;
                default:   st_nx = G_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= G_ARMED;
        else     st <= st_nx;
    end

    // R7: leaving the communicating mode clears the trip
    a_r7_off_clears: assert property (@(posedge clk) disable iff (rst)
        !norm_en |=> (st == G_ARMED));

    // R5: a trip holds until release is qualified
    a_r5_hold_trip: assert property (@(posedge clk) disable iff (rst)
        (st == G_TRIPPED && norm_en && !evt.rel_hit) |=> (st == G_TRIPPED));

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
    parameter int unsigned TMO_TICKS = 27000,
    parameter int unsigned REL_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic norm_en,
    input  logic txd_sync,
    output logic drv_dom,
    output logic tmo_flag,
    output logic txd_level
);
    import txg_pkg::*;

    localparam int unsigned LOW_LIM = TMO_TICKS + 1;
    localparam int unsigned REL_LIM = REL_TICKS + 1;

    guard_st_e  st;
    guard_evt_t evt;
    logic       low_clr;
    logic       hi_clr;

    assign low_clr = !norm_en || txd_sync;
    assign hi_clr  = !norm_en || !txd_sync || (st != G_TRIPPED);

    txg_tick_ctr #(.LIMIT(LOW_LIM)) u_low_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (low_clr),
        .tick  (tick),
        .full  (evt.trip_hit)
    );

    txg_tick_ctr #(.LIMIT(REL_LIM)) u_rel_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (hi_clr),
        .tick  (tick),
        .full  (evt.rel_hit)
    );

    txg_guard_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .norm_en (norm_en),
        .evt     (evt),
        .st      (st)
    );

    assign drv_dom   = norm_en && !txd_sync && (st == G_ARMED) && !evt.trip_hit;
    assign tmo_flag  = (st == G_TRIPPED);
    assign txd_level = txd_sync;

    // R1: a high transmit level never drives dominant
    a_r1_high_recessive: assert property (@(posedge clk) disable iff (rst)
        txd_sync |-> !drv_dom);

    // R2: a tripped guard never drives dominant
    a_r2_trip_blocks: assert property (@(posedge clk) disable iff (rst)
        tmo_flag |-> !drv_dom);

    // R7: outside the communicating mode the driver stays recessive
    a_r7_off_recessive: assert property (@(posedge clk) disable iff (rst)
        !norm_en |-> !drv_dom);

    // R6: the raw level is always visible to the mode controller
    a_r6_level_mirror: assert property (@(posedge clk) disable iff (rst)
        txd_level == txd_sync);

endmodule

// File: tb/tb_txd_dom_guard.sv
module tb_txd_dom_guard;

    localparam int unsigned TMO = 20;
    localparam int unsigned REL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic norm_en = 1'b1;
    logic txd_sync = 1'b1;
    logic drv_dom, tmo_flag, txd_level;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    txd_dom_guard #(.TMO_TICKS(TMO), .REL_TICKS(REL)) dut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .norm_en   (norm_en),
        .txd_sync  (txd_sync),
        .drv_dom   (drv_dom),
        .tmo_flag  (tmo_flag),
        .txd_level (txd_level)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; txd_sync = 1'b1; norm_en = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R8 flag after reset", tmo_flag, 1'b0);
        chk("R1 recessive after reset", drv_dom, 1'b0);
        txd_sync = 1'b0;
        step(1);
        chk("R8 count zero after reset", drv_dom, 1'b1);
        txd_sync = 1'b1;
        step(1);
    endtask

    task automatic t_bits();
        txd_sync = 1'b0; step(1);
        chk("R1 low drives dominant", drv_dom, 1'b1);
        txd_sync = 1'b1; step(1);
        chk("R1 high gives recessive", drv_dom, 1'b0);
        chk("R6 mirror high", txd_level, 1'b1);
    endtask

    task automatic t_trip();
        txd_sync = 1'b0;
        tk(TMO);
        chk("R2 no trip at limit", drv_dom, 1'b1);
        tk(1);
        chk("R2 recessive past limit", drv_dom, 1'b0);
        chk("R2 flag not yet", tmo_flag, 1'b0);
        step(1);
        chk("R2 flag raised", tmo_flag, 1'b1);
        chk("R6 mirror low while tripped", txd_level, 1'b0);
    endtask

    task automatic t_saturate();
        tk(40);
        chk("R4 stays recessive", drv_dom, 1'b0);
        chk("R4 stays tripped", tmo_flag, 1'b1);
    endtask

    task automatic t_release();
        txd_sync = 1'b1;
        tk(REL);
        step(1);
        chk("R5 not released early", tmo_flag, 1'b1);
        tk(1);
        step(1);
        chk("R5 released", tmo_flag, 1'b0);
        txd_sync = 1'b0; step(1);
        chk("R5 driver re-enabled", drv_dom, 1'b1);
    endtask

    task automatic t_restart();
        tk(TMO + 1); step(1);
        chk("R2 second trip", tmo_flag, 1'b1);
        txd_sync = 1'b1; tk(REL);
        txd_sync = 1'b0; step(1);
        chk("R5 low blocks driver", drv_dom, 1'b0);
        txd_sync = 1'b1; tk(REL); step(1);
        chk("R5 restart holds trip", tmo_flag, 1'b1);
        tk(1); step(1);
        chk("R5 release after restart", tmo_flag, 1'b0);
    endtask

    task automatic t_glitch();
        txd_sync = 1'b0; tk(TMO);
        txd_sync = 1'b1; step(1);
        txd_sync = 1'b0; tk(TMO);
        chk("R3 high sample resets count", drv_dom, 1'b1);
        step(1);
        chk("R3 no trip", tmo_flag, 1'b0);
        tk(1);
        chk("R3 trip after full run", drv_dom, 1'b0);
        step(1);
    endtask

    task automatic t_mode();
        chk("R7 tripped before mode drop", tmo_flag, 1'b1);
        norm_en = 1'b0; step(1);
        chk("R7 recessive when disabled", drv_dom, 1'b0);
        chk("R7 trip cleared", tmo_flag, 1'b0);
        chk("R6 low visible for sleep", txd_level, 1'b0);
        norm_en = 1'b1; step(1);
        chk("R7 count cleared", drv_dom, 1'b1);
        txd_sync = 1'b1; step(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_bits();
        t_trip();
        t_saturate();
        t_release();
        t_restart();
        t_glitch();
        t_mode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule